// File: doc/BRIEF.md
# High/Low Result Byte Read Pointer

This block decides which result byte a host receives on each data read from an analog-to-digital converter. In 10-bit mode every channel owns two result bytes, an upper and a lower one. A host that streams through the results has to get them in a fixed order: upper byte, then lower byte, then the next channel. The block holds a channel address and a one-bit byte-half pointer. On each data read strobe it reports the register index that the read selects, then moves the pointer forward. In 8-bit mode each channel has a single byte, the half pointer plays no part, and every read moves on to the next channel.

The host sets the pointer by writing a start-address byte. A load-enable bit in that byte decides whether the channel field and the half bit are copied into the pointer. Reading the byte back returns the channel field that was last written and the live half bit, so the host can tell which half the next read will fetch. The result storage and the host serial link are outside this block. A neighbour uses `rd_idx` to address the storage.

Top module: `hl_read_ptr`

## Requirements
- R1: After reset the channel pointer is 0, the half pointer is 0 (upper byte), `rd_valid` is 0 and `readback` is all zeros.
- R2: A write with the load bit `wr_data[4]` set copies `wr_data[3:1]` into the channel pointer and `wr_data[0]` into the half pointer (0 = upper byte, 1 = lower byte) in 10-bit mode (`mode_10b`=1). The new values show on the outputs after the clock edge that takes the write.
- R3: A write with `wr_data[4]` clear leaves the channel pointer and the half pointer unchanged.
- R4: In 10-bit mode, a read taken while the half pointer is 0 reports `rd_idx` = {channel, 0}. It then sets the half pointer to 1 and keeps the same channel.
- R5: In 10-bit mode, a read taken while the half pointer is 1 reports `rd_idx` = {channel, 1}. It then clears the half pointer and adds 1 to the channel.
- R6: The channel pointer wraps from its highest value (7) to 0 when it advances.
- R7: In 8-bit mode (`mode_10b`=0), `ptr_low` reads 0 and a loading write ignores `wr_data[0]`. Each read reports `rd_idx` = {channel, 0} and adds 1 to the channel.
- R8: `readback` returns the channel field of the most recent write in bits 3:1, whether or not that write loaded the pointer. Bit 0 holds the live half pointer and the upper bits are 0.
- R9: When a write and a read strobe arrive in the same cycle, the write is carried out and the read is dropped: no `rd_valid` pulse and no pointer advance.
- R10: `rd_valid` pulses high for exactly one cycle after each accepted read. `rd_idx` keeps its value until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_10b | input | 1 | 1 = two bytes per channel, 0 = one byte per channel |
| wr_en | input | 1 | Start-address write strobe |
| wr_data | input | 8 | Start-address byte: bit 4 load, bits 3:1 channel, bit 0 half |
| rd_en | input | 1 | Data register read strobe |
| rd_valid | output | 1 | One-cycle pulse after an accepted read |
| rd_idx | output | 4 | Register index chosen by the last read, {channel, half} |
| ptr_chan | output | 3 | Channel the next read will target |
| ptr_low | output | 1 | Half the next read will target (1 = lower byte) |
| readback | output | 8 | Start-address byte as read back by the host |

## Verification
The hardest case to reach is a pointer that sits on a lower byte at the last channel while the mode or the write strobe changes. The stimulus first loads channel 7 with the half bit clear and reads four times, so the sequence crosses the wrap with the half pointer toggling. It then loads a lower-byte start while in 8-bit mode, to show that the half bit is discarded. Finally it issues a write and a read in the same cycle, to show that the write has priority.

// File: rtl/hl_ptr_pkg.sv
package hl_ptr_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_LOAD    = 2'd1,
    ACT_TO_LOW  = 2'd2,
    ACT_NEXT_CH = 2'd3
  } ptr_act_e;

endpackage

// File: rtl/hl_ptr_decode.sv
module hl_ptr_decode
  import hl_ptr_pkg::*;
(
  input  logic     mode_10b,
  input  logic     wr_en,
  input  logic     wr_load,
  input  logic     rd_en,
  input  logic     cur_low,
  output ptr_act_e act,
  output logic     rd_take
);

  always_comb begin
    act     = ACT_HOLD;
    rd_take = 1'b0;
    if (wr_en) begin
      act = wr_load ? ACT_LOAD : ACT_HOLD;
    end else if (rd_en) begin
      rd_take = 1'b1;
      if (mode_10b && !cur_low) act = ACT_TO_LOW;
      else                      act = ACT_NEXT_CH;
    end
  end

endmodule

// File: rtl/hl_ptr_state.sv
module hl_ptr_state
  import hl_ptr_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_10b,
  input  ptr_act_e        act,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  input  logic            wr_low,
  output logic [CH_W-1:0] chan_q,
  output logic            low_eff,
  output logic [CH_W-1:0] echo_q
);

  logic low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      low_q  <= 1'b0;
      echo_q <= '0;
    end else begin
      if (wr_en) echo_q <= wr_chan;
      case (act)
        ACT_LOAD: begin
          chan_q <= wr_chan;
          low_q  <= wr_low & mode_10b;
        end
        ACT_TO_LOW:  low_q <= 1'b1;
        ACT_NEXT_CH: begin
          chan_q <= chan_q + 1'b1;
          low_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign low_eff = low_q & mode_10b;

endmodule

// File: rtl/hl_ptr_out.sv
module hl_ptr_out #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_take,
  input  logic [IDX_W-1:0] idx_now,
  output logic             rd_valid,
  output logic [IDX_W-1:0] rd_idx
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_idx   <= '0;
    end else begin
      rd_valid <= rd_take;
      if (rd_take) rd_idx <= idx_now;
    end
  end

endmodule

// File: rtl/hl_read_ptr.sv
module hl_read_ptr
  import hl_ptr_pkg::*;
#(
  parameter int CH_W = 3,
  parameter int WR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_10b,
  input  logic            wr_en,
  input  logic [WR_W-1:0] wr_data,
  input  logic            rd_en,
  output logic            rd_valid,
  output logic [CH_W:0]   rd_idx,
  output logic [CH_W-1:0] ptr_chan,
  output logic            ptr_low,
  output logic [WR_W-1:0] readback
);

  localparam int LOAD_BIT = CH_W + 1;
  localparam int IDX_W    = CH_W + 1;
  localparam int PAD_W    = WR_W - IDX_W;

  ptr_act_e        act;
  logic            rd_take;
  logic [CH_W-1:0] chan_q;
  logic [CH_W-1:0] echo_q;
  logic            low_eff;

  hl_ptr_decode u_decode (
    .mode_10b (mode_10b),
    .wr_en    (wr_en),
    .wr_load  (wr_data[LOAD_BIT]),
    .rd_en    (rd_en),
    .cur_low  (low_eff),
    .act      (act),
    .rd_take  (rd_take)
  );

  hl_ptr_state #(.CH_W(CH_W)) u_state (
    .clk      (clk),
    .rst      (rst),
    .mode_10b (mode_10b),
    .act      (act),
    .wr_en    (wr_en),
    .wr_chan  (wr_data[CH_W:1]),
    .wr_low   (wr_data[0]),
    .chan_q   (chan_q),
    .low_eff  (low_eff),
    .echo_q   (echo_q)
  );

  hl_ptr_out #(.IDX_W(IDX_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .rd_take  (rd_take),
    .idx_now  ({chan_q, low_eff}),
    .rd_valid (rd_valid),
    .rd_idx   (rd_idx)
  );

  assign ptr_chan = chan_q;
  assign ptr_low  = low_eff;

  generate
    if (PAD_W > 0) begin : g_pad
      assign readback = {{PAD_W{1'b0}}, echo_q, low_eff};
    end else begin : g_nopad
      assign readback = {echo_q, low_eff};
    end
  endgenerate

endmodule

// File: rtl/hl_read_ptr_chk.sv
module hl_read_ptr_chk #(
  parameter int CH_W = 3,
  parameter int WR_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            mode_10b,
  input logic            wr_en,
  input logic [WR_W-1:0] wr_data,
  input logic            rd_en,
  input logic            rd_valid,
  input logic [CH_W:0]   rd_idx,
  input logic [CH_W-1:0] ptr_chan,
  input logic            ptr_low
);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[CH_W+1] && mode_10b) |=>
      (ptr_chan == $past(wr_data[CH_W:1]) && ptr_low == $past(wr_data[0])));

  assert_noload_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[CH_W+1]) |=> $stable(ptr_chan));

  assert_upper_then_lower_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && mode_10b && !ptr_low) |=>
      (ptr_low && $stable(ptr_chan) && !rd_idx[0]));

  assert_lower_then_next_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && mode_10b && ptr_low) |=>
      (!ptr_low && rd_idx[0] && ptr_chan == CH_W'($past(ptr_chan) + 1'b1)));

  assert_byte_mode_step_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !mode_10b) |=>
      (!rd_idx[0] && ptr_chan == CH_W'($past(ptr_chan) + 1'b1)));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> !rd_valid);

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> rd_valid);

  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !wr_en) |=> (!rd_valid && $stable(rd_idx)));

endmodule

bind hl_read_ptr hl_read_ptr_chk #(.CH_W(CH_W), .WR_W(WR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_10b (mode_10b),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .rd_idx   (rd_idx),
  .ptr_chan (ptr_chan),
  .ptr_low  (ptr_low)
);

// File: tb/tb_hl_read_ptr.sv
module tb_hl_read_ptr;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_10b = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic       rd_valid;
  logic [3:0] rd_idx;
  logic [2:0] ptr_chan;
  logic       ptr_low;
  logic [7:0] readback;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  logic [2:0] m_chan = '0;
  logic       m_low = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hl_read_ptr dut (
    .clk(clk), .rst(rst), .mode_10b(mode_10b), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_idx(rd_idx), .ptr_chan(ptr_chan), .ptr_low(ptr_low),
    .readback(readback)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops an expected index for every rd_valid pulse
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected rd_valid", 1, 0);
      end else begin
        check("R4/R5/R7 rd_idx", rd_idx, exp_q.pop_front());
      end
    end
  end

  task automatic do_read();
    @(negedge clk);
    rd_en = 1'b1;
    exp_q.push_back({m_chan, m_low & mode_10b});
    if (mode_10b && !m_low) begin
      m_low = 1'b1;
    end else begin
      m_chan = m_chan + 3'd1;
      m_low  = 1'b0;
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    if (d[4]) begin
      m_chan = d[3:1];
      m_low  = d[0] & mode_10b;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_ptr(input string req);
    check(req, ptr_chan, m_chan);
    check(req, ptr_low, m_low);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 chan", ptr_chan, 0);
    check("R1 low", ptr_low, 0);
    check("R1 valid", rd_valid, 0);
    check("R1 readback", readback, 0);

    // R4 R5: upper, lower, upper, lower from channel 0
    for (int i = 0; i < 4; i++) do_read();
    check_ptr("R5 after 4 reads");
    check("R5 chan", ptr_chan, 2);

    // R2 R8: load channel 5 lower byte
    do_write(8'h1B);
    check("R2 chan", ptr_chan, 5);
    check("R2 low", ptr_low, 1);
    check("R8 readback", readback, 8'h0B);
    do_read();
    check("R5 next chan", ptr_chan, 6);
    check("R5 low cleared", ptr_low, 0);

    // R3 R8: no-load write keeps pointer, echoes field
    do_write(8'h07);
    check_ptr("R3 unchanged");
    check("R8 echo live half", readback, 8'h06);

    // R6: wrap
    do_write(8'h1E);
    for (int i = 0; i < 4; i++) do_read();
    check("R6 wrap chan", ptr_chan, 1);
    check_ptr("R6 state");

    // R7: 8-bit mode
    mode_10b = 1'b0;
    do_write(8'h13);
    check("R7 low ignored", ptr_low, 0);
    check("R7 chan", ptr_chan, 1);
    check("R8 readback 8b", readback, 8'h02);
    for (int i = 0; i < 3; i++) do_read();
    check("R7 chan step", ptr_chan, 4);

    // R9: write and read together
    mode_10b = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h15;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    m_chan = 3'd2; m_low = 1'b1;
    check("R9 no valid", rd_valid, 0);
    check_ptr("R9 write applied");

    repeat (3) @(negedge clk);
    check("R10 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule